// File: doc/BRIEF.md
# Bus master security filter

This block is placed on the path from a single bus master to the downstream memory system. Every access the master issues is classified, and the block decides whether it reaches memory and which security attribute it carries there. An external attribution unit, outside this block, looks at the request address and drives two classification bits into the filter: exempt and non-secure. An address with neither bit set is a secure region.

Two configuration inputs set how the master is treated. The first says whether the master is non-secure. The second selects how a blocked access ends: either quietly, with an OKAY response, or with an error response and a sticky interrupt. A clear input, while it is high, holds the interrupt status at zero.

Requests and responses use valid/ready handshakes on both sides, and only one transaction is in flight at a time. The classification and configuration inputs are captured when a request is accepted, and those captured values govern the whole transaction.

Top module: `sec_filter`

## Requirements
- R1: An exempt address (`attr_exempt`=1) is forwarded with `dn_ns` equal to `cfg_master_ns` (`dn_ns`=1 means non-secure). Exempt takes priority over `attr_ns`.
- R2: A non-exempt address with `attr_ns`=1 is forwarded with `dn_ns`=1 whatever `cfg_master_ns` is.
- R3: An address with both bits low (a secure region), accessed while `cfg_master_ns`=0, is forwarded with `dn_ns`=0.
- R4: A secure-region access while `cfg_master_ns`=1 is blocked and never raises `dn_req_valid`.
- R5: A blocked access with `cfg_err_mode`=0 completes with `up_rsp_err`=0. A blocked read returns all-zero data, and a blocked write is dropped.
- R6: A blocked access with `cfg_err_mode`=1 completes with `up_rsp_err`=1. It sets the interrupt status when `irq_clr` is low in its accept cycle.
- R7: `irq` shows the status register. The status stays set until a cycle with `irq_clr`=1, and it reads 0 after every such cycle. If a clear and a set fall in the same cycle, the clear wins.
- R8: After reset, `up_req_ready`=1, `irq`=0, and `dn_req_valid` and `up_rsp_valid` are both 0.
- R9: On a forwarded access, `dn_addr`, `dn_wdata`, `dn_size` and `dn_write` equal the accepted request. `dn_req_valid` and its fields are held until `dn_req_ready`. The downstream error flag is returned unchanged.
- R10: `up_req_ready` is low from acceptance until the response handshake. For a forwarded access with the downstream side always ready and answering in the next cycle, `up_rsp_valid` rises 3 cycles after acceptance. For a blocked access it rises 1 cycle after acceptance.
- R11: Changes to the classification, configuration or request inputs after acceptance do not affect the transaction in flight.
- R12: Size code `s` (0..3) means 2^s bytes, little-endian, with byte 0 in bits 7:0. Read-data bytes at or above 2^s are returned as zero, and a write response returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Filter can accept a request |
| up_addr | input | AW | Request address |
| up_wdata | input | DW | Write data |
| up_size | input | 2 | Size code, 2^code bytes |
| up_write | input | 1 | 1 = write, 0 = read |
| attr_exempt | input | 1 | Address is exempt from checking |
| attr_ns | input | 1 | Address is a non-secure region |
| cfg_master_ns | input | 1 | Master is configured non-secure |
| cfg_err_mode | input | 1 | Blocked access ends with an error and interrupt |
| irq_clr | input | 1 | Interrupt clear, level sensitive |
| up_rsp_valid | output | 1 | Response to master valid |
| up_rsp_ready | input | 1 | Master accepts the response |
| up_rsp_rdata | output | DW | Read data |
| up_rsp_err | output | 1 | Error response |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts the request |
| dn_addr | output | AW | Downstream address |
| dn_wdata | output | DW | Downstream write data |
| dn_size | output | 2 | Downstream size code |
| dn_write | output | 1 | Downstream write flag |
| dn_ns | output | 1 | Security attribute, 1 = non-secure |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_ready | output | 1 | Filter accepts a downstream response |
| dn_rsp_rdata | input | DW | Downstream read data |
| dn_rsp_err | input | 1 | Downstream error |
| irq | output | 1 | Security violation interrupt |

## Verification
A wrongly captured classification or configuration shows up in the first cycle `dn_req_valid` is high, as a wrong `dn_ns`. In a blocked case it shows up instead as a downstream request that should not exist, or as a response arriving at the wrong time. A fault in the sequencing state moves `up_req_ready` or `up_rsp_valid` off their fixed 1- or 3-cycle timing, and this is visible in the very cycle it happens. A fault in the interrupt register appears on `irq` in the cycle after the accept or clear edge that should have changed it. Because of this, the bench predicts and compares all of these outputs on every clock.

// File: rtl/sf_pkg.sv
package sf_pkg;
  typedef enum logic [1:0] {
    ACT_BLOCK_OK  = 2'd0,
    ACT_BLOCK_ERR = 2'd1,
    ACT_FWD_SEC   = 2'd2,
    ACT_FWD_NS    = 2'd3
  } sf_act_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DREQ = 2'd1,
    ST_DRSP = 2'd2,
    ST_URSP = 2'd3
  } sf_st_e;
endpackage

// File: rtl/sf_policy.sv
module sf_policy
  import sf_pkg::*;
(
  input  logic    exempt,
  input  logic    ns_region,
  input  logic    master_ns,
  input  logic    err_mode,
  output sf_act_e act
);
  always_comb begin
    if (exempt)          act = master_ns ? ACT_FWD_NS : ACT_FWD_SEC;
    else if (ns_region)  act = ACT_FWD_NS;
    else if (!master_ns) act = ACT_FWD_SEC;
    else                 act = err_mode ? ACT_BLOCK_ERR : ACT_BLOCK_OK;
  end
endmodule

// File: rtl/sf_lane_mask.sv
module sf_lane_mask #(
  parameter int DW  = 64,
  parameter int SZW = 2
) (
  input  logic [DW-1:0]  din,
  input  logic [SZW-1:0] size,
  output logic [DW-1:0]  dout
);
  localparam int LANES = DW / 8;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [7:0] LI = 8'(i);
    logic keep;
    assign keep = ((LI >> size) == 8'd0);
    assign dout[8*i +: 8] = keep ? din[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/sf_irq.sv
module sf_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (clr)     irq <= 1'b0;
    else if (set_req) irq <= 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst) clr |=> !irq); // R7
  AST_SET_ON_BLOCK: assert property (@(posedge clk) disable iff (rst) (set_req && !clr) |=> irq); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (rst) (irq && !clr) |=> irq); // R7
endmodule

// File: rtl/sec_filter.sv
module sec_filter
  import sf_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 64,
  parameter int SZW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           up_req_valid,
  output logic           up_req_ready,
  input  logic [AW-1:0]  up_addr,
  input  logic [DW-1:0]  up_wdata,
  input  logic [SZW-1:0] up_size,
  input  logic           up_write,
  input  logic           attr_exempt,
  input  logic           attr_ns,
  input  logic           cfg_master_ns,
  input  logic           cfg_err_mode,
  input  logic           irq_clr,
  output logic           up_rsp_valid,
  input  logic           up_rsp_ready,
  output logic [DW-1:0]  up_rsp_rdata,
  output logic           up_rsp_err,
  output logic           dn_req_valid,
  input  logic           dn_req_ready,
  output logic [AW-1:0]  dn_addr,
  output logic [DW-1:0]  dn_wdata,
  output logic [SZW-1:0] dn_size,
  output logic           dn_write,
  output logic           dn_ns,
  input  logic           dn_rsp_valid,
  output logic           dn_rsp_ready,
  input  logic [DW-1:0]  dn_rsp_rdata,
  input  logic           dn_rsp_err,
  output logic           irq
);
  sf_st_e          st;
  sf_act_e         act_d, act_q;
  logic            accept, fwd_d;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q, masked;
  logic [SZW-1:0]  size_q;
  logic            write_q, err_q;

  sf_policy u_policy (
    .exempt    (attr_exempt),
    .ns_region (attr_ns),
    .master_ns (cfg_master_ns),
    .err_mode  (cfg_err_mode),
    .act       (act_d)
  );

  sf_lane_mask #(.DW(DW), .SZW(SZW)) u_mask (
    .din  (dn_rsp_rdata),
    .size (size_q),
    .dout (masked)
  );

  sf_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_req (accept && (act_d == ACT_BLOCK_ERR)),
    .clr     (irq_clr),
    .irq     (irq)
  );

  assign accept = up_req_valid && (st == ST_IDLE);
  assign fwd_d  = (act_d == ACT_FWD_SEC) || (act_d == ACT_FWD_NS);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      act_q   <= ACT_BLOCK_OK;
      addr_q  <= '0;
      wdata_q <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (up_req_valid) begin
          act_q   <= act_d;
          addr_q  <= up_addr;
          wdata_q <= up_wdata;
          size_q  <= up_size;
          write_q <= up_write;
          if (fwd_d) begin
            st <= ST_DREQ;
          end else begin
            st      <= ST_URSP;
            rdata_q <= '0;
            err_q   <= (act_d == ACT_BLOCK_ERR);
          end
        end
        ST_DREQ: if (dn_req_ready) st <= ST_DRSP;
        ST_DRSP: if (dn_rsp_valid) begin
          rdata_q <= write_q ? '0 : masked;
          err_q   <= dn_rsp_err;
          st      <= ST_URSP;
        end
        ST_URSP: if (up_rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign up_req_ready = (st == ST_IDLE);
  assign dn_req_valid = (st == ST_DREQ);
  assign dn_rsp_ready = (st == ST_DRSP);
  assign up_rsp_valid = (st == ST_URSP);
  assign up_rsp_rdata = rdata_q;
  assign up_rsp_err   = err_q;
  assign dn_addr      = addr_q;
  assign dn_wdata     = wdata_q;
  assign dn_size      = size_q;
  assign dn_write     = write_q;
  assign dn_ns        = (act_q == ACT_FWD_NS);

  AST_BLOCK_LOCAL: assert property (@(posedge clk) disable iff (rst)
    (accept && !fwd_d) |=> (!dn_req_valid && up_rsp_valid)); // R4
  AST_SILENT_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (up_rsp_valid && act_q == ACT_BLOCK_OK) |-> (!up_rsp_err && up_rsp_rdata == '0)); // R5
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_addr) && $stable(dn_ns))); // R9
  AST_ERR_PASS: assert property (@(posedge clk) disable iff (rst)
    (dn_rsp_ready && dn_rsp_valid) |=> (up_rsp_err == $past(dn_rsp_err))); // R9
endmodule

// File: tb/sim_sec_filter.sv
`timescale 1ns/1ps
module sim_sec_filter;
  localparam int AW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic up_req_valid, up_req_ready, up_write, attr_exempt, attr_ns;
  logic cfg_master_ns, cfg_err_mode, irq_clr;
  logic up_rsp_valid, up_rsp_ready, up_rsp_err;
  logic dn_req_valid, dn_req_ready, dn_write, dn_ns;
  logic dn_rsp_valid, dn_rsp_ready, dn_rsp_err, irq;
  logic [AW-1:0] up_addr, dn_addr;
  logic [DW-1:0] up_wdata, up_rsp_rdata, dn_wdata, dn_rsp_rdata;
  logic [1:0]    up_size, dn_size;

  sec_filter #(.AW(AW), .DW(DW), .SZW(2)) u0 (.*);

  int checks = 0;
  int errors = 0;

  // reference model state
  int          m_left = 0;
  bit          m_fwd, m_ns, m_berr, m_irq = 1'b0;
  logic [31:0] m_addr;
  logic [63:0] m_wdata;
  logic [1:0]  m_size;
  bit          m_write;

  function automatic logic [63:0] dn_data(logic [31:0] a);
    return 64'h0123_4567_89AB_CDEF ^ {a, a};
  endfunction

  function automatic bit dn_errf(logic [31:0] a);
    return a[31:28] == 4'hE;
  endfunction

  function automatic logic [63:0] lane_mask(logic [1:0] s);
    return (s == 2'd3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * (1 << s))) - 64'd1);
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(string tag);
    bit acc;
    logic [63:0] exp_d;
    bit exp_e;
    acc = up_req_valid && (m_left == 0);
    if (acc) begin
      m_addr = up_addr; m_wdata = up_wdata; m_size = up_size; m_write = up_write;
      m_berr = 1'b0;
      if (attr_exempt)        begin m_fwd = 1; m_ns = cfg_master_ns; end
      else if (attr_ns)       begin m_fwd = 1; m_ns = 1; end
      else if (!cfg_master_ns) begin m_fwd = 1; m_ns = 0; end
      else                    begin m_fwd = 0; m_ns = 0; m_berr = cfg_err_mode; end
    end
    if (irq_clr) m_irq = 1'b0;
    else if (acc && m_berr) m_irq = 1'b1;
    @(posedge clk);
    if (m_left > 0) m_left--;
    else if (acc) m_left = m_fwd ? 3 : 1;
    @(negedge clk);
    chk(irq == m_irq, {tag, " R7 irq"}, 64'(irq), 64'(m_irq));
    chk(up_req_ready == (m_left == 0), {tag, " R10 ready"}, 64'(up_req_ready), 64'(m_left == 0));
    chk(up_rsp_valid == (m_left == 1), {tag, " R10 rsp_valid"}, 64'(up_rsp_valid), 64'(m_left == 1));
    chk(dn_req_valid == (m_fwd && m_left == 3), {tag, " R4 dn_req_valid"},
        64'(dn_req_valid), 64'(m_fwd && m_left == 3));
    if (dn_req_valid && m_left == 3) begin
      chk(dn_ns == m_ns, {tag, " dn_ns"}, 64'(dn_ns), 64'(m_ns));
      chk(dn_addr == m_addr, {tag, " R9 addr"}, 64'(dn_addr), 64'(m_addr));
      chk(dn_wdata == m_wdata, {tag, " R9 wdata"}, dn_wdata, m_wdata);
      chk(dn_size == m_size && dn_write == m_write, {tag, " R9 size/write"},
          64'({dn_size, dn_write}), 64'({m_size, m_write}));
    end
    if (up_rsp_valid && m_left == 1) begin
      exp_d = (m_fwd && !m_write) ? (dn_data(m_addr) & lane_mask(m_size)) : 64'd0;
      exp_e = m_fwd ? dn_errf(m_addr) : m_berr;
      chk(up_rsp_rdata == exp_d, {tag, " R12 rdata"}, up_rsp_rdata, exp_d);
      chk(up_rsp_err == exp_e, {tag, " err"}, 64'(up_rsp_err), 64'(exp_e));
    end
    // downstream model: answers in the cycle after its request is taken
    dn_rsp_valid = m_fwd && (m_left == 2);
    dn_rsp_rdata = dn_data(dn_addr);
    dn_rsp_err   = dn_errf(dn_addr);
  endtask

  task automatic txn(string tag, logic [31:0] a, logic [63:0] wd, logic [1:0] sz, bit wr,
                     bit ex, bit nsr, bit mns, bit em);
    up_addr = a; up_wdata = wd; up_size = sz; up_write = wr;
    attr_exempt = ex; attr_ns = nsr; cfg_master_ns = mns; cfg_err_mode = em;
    up_req_valid = 1'b1;
    tick(tag);
    up_req_valid = 1'b0;
    // R11: disturb every sampled input while the transaction runs
    up_addr = ~a; up_wdata = ~wd; up_size = ~sz; up_write = ~wr;
    attr_exempt = ~ex; attr_ns = ~nsr; cfg_master_ns = ~mns; cfg_err_mode = ~em;
    while (m_left > 0) tick(tag);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; up_req_valid = 0; up_addr = 0; up_wdata = 0; up_size = 0; up_write = 0;
    attr_exempt = 0; attr_ns = 0; cfg_master_ns = 0; cfg_err_mode = 0; irq_clr = 0;
    up_rsp_ready = 1; dn_req_ready = 1; dn_rsp_valid = 0; dn_rsp_rdata = 0; dn_rsp_err = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(up_req_ready == 1 && irq == 0 && dn_req_valid == 0 && up_rsp_valid == 0,
        "R8 reset state", 64'({up_req_ready, irq, dn_req_valid, up_rsp_valid}), 64'b1000);

    txn("R3 secure master secure region", 32'h0000_0100, 64'h1111_2222_3333_4444, 2'd3, 0, 0, 0, 0, 0);
    txn("R1 exempt ns master write",      32'h0000_0208, 64'hDEAD_BEEF_CAFE_F00D, 2'd2, 1, 1, 0, 1, 0);
    txn("R1 exempt secure master byte",   32'h0000_0301, 64'h0, 2'd0, 0, 1, 0, 0, 0);
    txn("R1 exempt beats ns bit",         32'h0000_0310, 64'h0, 2'd2, 0, 1, 1, 0, 0);
    txn("R2 ns region secure master",     32'h0000_0402, 64'h0, 2'd1, 0, 0, 1, 0, 1);
    txn("R2 ns region ns master",         32'h0000_0404, 64'h5A5A, 2'd1, 1, 0, 1, 1, 1);
    txn("R9 downstream error passes",     32'hE000_0010, 64'h0, 2'd3, 0, 0, 1, 1, 0);
    txn("R5 silent block read",           32'h1000_0000, 64'h0, 2'd3, 0, 0, 0, 1, 0);
    txn("R5 silent block write",          32'h1000_0008, 64'h7777, 2'd3, 1, 0, 0, 1, 0);
    txn("R6 error block read",            32'h1000_0010, 64'h0, 2'd2, 0, 0, 0, 1, 1);
    txn("R7 sticky over forward",         32'h0000_0500, 64'h0, 2'd3, 0, 0, 1, 0, 0);
    tick("R7 idle keep");
    irq_clr = 1'b1;
    tick("R7 clear pulse");
    irq_clr = 1'b0;
    tick("R7 after clear");
    irq_clr = 1'b1;
    txn("R7 clear beats block set",       32'h1000_0020, 64'h0, 2'd3, 1, 0, 0, 1, 1);
    irq_clr = 1'b0;
    tick("R7 still clear");
    txn("R6 error block write",           32'h1000_0028, 64'h99, 2'd1, 1, 0, 0, 1, 1);
    txn("R11 sampled then disturbed",     32'h0000_0600, 64'h0, 2'd1, 0, 0, 0, 0, 1);
    for (int s = 0; s < 4; s++)
      txn("R12 size sweep", 32'h0000_0700 + 32'(s), 64'h0, 2'(s), 0, 0, 1, 0, 0);
    // back-to-back requests: valid held, acceptance only when idle
    up_addr = 32'h0000_0800; up_size = 2'd3; up_write = 0;
    attr_exempt = 0; attr_ns = 1; cfg_master_ns = 1; cfg_err_mode = 0;
    up_req_valid = 1'b1;
    repeat (9) tick("R10 held valid");
    up_req_valid = 1'b0;
    while (m_left > 0) tick("R10 drain");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule